// File: doc/BRIEF.md
# Vector Element to Port Distributor

This block sits between a wide vector source (a vector register or a memory line holding eight 32-bit elements) and a small dataflow fabric with four input ports and four output ports. On the inbound side it accepts one vector word per handshake and pushes chosen elements into the FIFO behind each input port. A run-time loadable table sets, for every port, an ordered list of up to four element indices. One port can therefore take several non-adjacent elements in a chosen order, and strided or interleaved layouts can feed the fabric without repacking.

On the outbound side a second table of the same shape gathers results from the four output-port FIFOs back into one vector word. The vector is offered only when every mapped output FIFO holds enough elements for one word. All of those elements are then popped in the same cycle. Lanes that no port fills carry zero data and a zero byte-enable.

The tables are written entry by entry into a shadow copy and become active on a commit. Writes and commits are only accepted while every FIFO is empty. While a load is pending, vector traffic is held off.

Top module: `vec_port_router`

## Requirements
- R1: After reset, vin_ready is 1, vout_valid is 0, cfg_busy is 0, every ip_valid bit is 0, every op_ready bit is 1, and both tables hold no valid entries.
- R2: A map entry is 4 bits, bit 3 valid and bits 2:0 an element index; lane e of a vector occupies bits [32e+31:32e]. On an accepted vector, each input FIFO receives the elements named by its valid entries in slot order 0 to 3, skipping invalid slots, whatever the index order.
- R3: Each FIFO is 4 deep. vin_ready is 0 whenever any input FIFO has fewer free places than the number of valid entries in its scatter map, and returns to 1 once the fabric pops enough.
- R4: An element named by no scatter entry reaches no port. An element named by entries of several ports reaches each of those ports.
- R5: vout_valid is 1 only when at least one gather entry is valid and every output FIFO holds at least as many elements as its valid gather entries. A vout handshake removes exactly that many elements from each output FIFO in the same cycle.
- R6: In the gathered word, the k-th valid entry of an output port takes that port's k-th oldest element and places it in the lane named by the entry. vout_be has 4 bits per lane: 4'hF for lanes named by some gather entry and 0 elsewhere, where the data is also 0.
- R7: Table writes and commits are ignored unless all eight FIFOs are empty. A written entry has no effect on traffic until a commit of that table.
- R8: cfg_busy rises after an accepted table write and stays high until that table is committed. While it is high, vin_ready and vout_valid are 0.
- R9: ip_valid[p] is 1 exactly when input FIFO p holds data, and op_ready[p] is 0 exactly when output FIFO p holds 4 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one table entry into the shadow table |
| cfg_side | input | 1 | Table select: 0 scatter, 1 gather |
| cfg_port | input | 2 | Port whose list is written |
| cfg_slot | input | 2 | Position in that port's list |
| cfg_ent | input | 4 | Entry: bit 3 valid, bits 2:0 element index |
| cfg_commit | input | 1 | Make the selected shadow table active |
| cfg_busy | output | 1 | A table load is pending |
| vin_valid | input | 1 | Vector word offered for scatter |
| vin_ready | output | 1 | Scatter can take the word this cycle |
| vin_data | input | 256 | Eight 32-bit lanes |
| ip_valid | output | 4 | Input-port FIFO holds data, one bit per port |
| ip_data | output | 128 | Head element of each input-port FIFO, 32 bits per port |
| ip_pop | input | 4 | Fabric takes the head element, one bit per port |
| op_push | input | 4 | Fabric writes a result, one bit per port |
| op_data | input | 128 | Result data, 32 bits per port |
| op_ready | output | 4 | Output-port FIFO has room, one bit per port |
| vout_valid | output | 1 | Gathered vector available |
| vout_ready | input | 1 | Consumer takes the gathered vector |
| vout_data | output | 256 | Gathered eight 32-bit lanes |
| vout_be | output | 32 | Byte enables, 4 per lane |

## Verification
The scatter map used in the bench lists its indices out of order, skips a slot, gives one element to two ports and leaves another element unmapped. A contiguous lane wiring, an index-sorted push or a failure to skip slots each produce a visible mismatch in the per-port scoreboard. Backpressure is tried at the exact boundary where one more word fits and where it does not. Gather is tried with one FIFO short and one FIFO filled to depth, which separates a word assembled too early from one popped in the wrong order or placed in the wrong lane. Table writes attempted while a FIFO holds data, followed by traffic through the old map, show whether locked writes leak into the active table.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
  localparam int NELEM  = 8;
  localparam int NPORT  = 4;
  localparam int MAPD   = 4;
  localparam int DW     = 32;
  localparam int FDEPTH = 4;

  localparam int IDXW = $clog2(NELEM);
  localparam int PW   = $clog2(NPORT);
  localparam int SW   = $clog2(MAPD);
  localparam int CNTW = $clog2(FDEPTH + 1);
  localparam int BEW  = DW / 8;

  typedef struct packed {
    logic            vld;
    logic [IDXW-1:0] idx;
  } ent_t;

  typedef ent_t [MAPD-1:0] pmap_t;
  typedef pmap_t [NPORT-1:0] tbl_t;

  // number of valid entries in one port list
  function automatic logic [CNTW-1:0] used_slots(input pmap_t m);
    logic [CNTW-1:0] c;
    c = '0;
    for (int s = 0; s < MAPD; s++)
      if (m[s].vld) c = c + CNTW'(1);
    return c;
  endfunction

  // position of slot s among the valid entries of a list
  function automatic logic [SW-1:0] rank_of(input pmap_t m, input int s);
    logic [SW-1:0] r;
    r = '0;
    for (int k = 0; k < MAPD; k++)
      if (k < s && m[k].vld) r = r + SW'(1);
    return r;
  endfunction
endpackage

// File: rtl/vpr_fifo.sv
module vpr_fifo
  import vpr_pkg::*;
#(
  parameter int FW    = 32,
  parameter int DEPTH = 4,
  parameter int NPUSH = 4,
  parameter int NPEEK = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CNTW-1:0]             push_n,
  input  logic [NPUSH-1:0][FW-1:0]    push_d,
  input  logic [CNTW-1:0]             pop_n,
  output logic [CNTW-1:0]             level,
  output logic [NPEEK-1:0][FW-1:0]    peek
);
  localparam int AW = $clog2(DEPTH);

  logic [DEPTH-1:0][FW-1:0] mem;
  logic [AW-1:0]            wptr;
  logic [AW-1:0]            rptr;

  always_ff @(posedge clk) begin
    for (int j = 0; j < NPUSH; j++)
      if (CNTW'(j) < push_n) mem[wptr + AW'(j)] <= push_d[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      wptr  <= wptr + AW'(push_n);
      rptr  <= rptr + AW'(pop_n);
      level <= level + push_n - pop_n;
    end
  end

  always_comb begin
    for (int j = 0; j < NPEEK; j++) peek[j] = mem[rptr + AW'(j)];
  end

  // R9: never write past the depth, never read what is not there
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_n <= CNTW'(DEPTH) - level);
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_n <= level);
endmodule

// File: rtl/vpr_map.sv
module vpr_map
  import vpr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_port,
  input  logic [SW-1:0] wr_slot,
  input  ent_t          wr_ent,
  input  logic          commit,
  output tbl_t          active,
  output logic          busy
);
  tbl_t shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
      busy   <= 1'b0;
    end else begin
      if (wr_en) begin
        shadow[wr_port][wr_slot] <= wr_ent;
        busy <= 1'b1;
      end
      if (commit) begin
        active <= shadow;
        busy   <= 1'b0;
      end
    end
  end

  // R8: pending flag follows write and commit
  a_r8_write_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !commit |=> busy);
  a_r8_commit_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
endmodule

// File: rtl/vec_port_router.sv
module vec_port_router
  import vpr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_side,
  input  logic [PW-1:0]          cfg_port,
  input  logic [SW-1:0]          cfg_slot,
  input  logic [IDXW:0]          cfg_ent,
  input  logic                   cfg_commit,
  output logic                   cfg_busy,
  input  logic                   vin_valid,
  output logic                   vin_ready,
  input  logic [NELEM*DW-1:0]    vin_data,
  output logic [NPORT-1:0]       ip_valid,
  output logic [NPORT*DW-1:0]    ip_data,
  input  logic [NPORT-1:0]       ip_pop,
  input  logic [NPORT-1:0]       op_push,
  input  logic [NPORT*DW-1:0]    op_data,
  output logic [NPORT-1:0]       op_ready,
  output logic                   vout_valid,
  input  logic                   vout_ready,
  output logic [NELEM*DW-1:0]    vout_data,
  output logic [NELEM*BEW-1:0]   vout_be
);
  tbl_t smap, gmap;
  logic busy_s, busy_g;
  logic all_empty, cfg_ok;
  logic s_wr, g_wr, s_cm, g_cm;
  logic vin_fire, vout_fire;

  logic [CNTW-1:0] ilevel [NPORT];
  logic [CNTW-1:0] olevel [NPORT];
  logic [CNTW-1:0] s_need [NPORT];
  logic [CNTW-1:0] g_need [NPORT];
  logic [NPORT-1:0] s_room, g_enough, g_any;
  logic [MAPD-1:0][DW-1:0] ipush_d [NPORT];
  logic [MAPD-1:0][DW-1:0] opeek   [NPORT];
  logic [DW-1:0] vin_lane [NELEM];

  // ---------------- configuration ----------------
  assign cfg_ok   = all_empty;
  assign s_wr     = cfg_we & cfg_ok & ~cfg_side;
  assign g_wr     = cfg_we & cfg_ok & cfg_side;
  assign s_cm     = cfg_commit & ~cfg_we & cfg_ok & ~cfg_side;
  assign g_cm     = cfg_commit & ~cfg_we & cfg_ok & cfg_side;
  assign cfg_busy = busy_s | busy_g;

  vpr_map u_smap (
    .clk(clk), .rst_n(rst_n), .wr_en(s_wr), .wr_port(cfg_port), .wr_slot(cfg_slot),
    .wr_ent(ent_t'(cfg_ent)), .commit(s_cm), .active(smap), .busy(busy_s));

  vpr_map u_gmap (
    .clk(clk), .rst_n(rst_n), .wr_en(g_wr), .wr_port(cfg_port), .wr_slot(cfg_slot),
    .wr_ent(ent_t'(cfg_ent)), .commit(g_cm), .active(gmap), .busy(busy_g));

  // ---------------- scatter ----------------
  always_comb begin
    for (int e = 0; e < NELEM; e++) vin_lane[e] = vin_data[e*DW +: DW];
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      s_need[p]  = used_slots(smap[p]);
      s_room[p]  = (CNTW'(FDEPTH) - ilevel[p]) >= s_need[p];
      ipush_d[p] = '0;
      for (int s = 0; s < MAPD; s++)
        if (smap[p][s].vld) ipush_d[p][rank_of(smap[p], s)] = vin_lane[smap[p][s].idx];
    end
  end

  assign vin_ready = (&s_room) & ~cfg_busy;
  assign vin_fire  = vin_valid & vin_ready;

  // ---------------- gather ----------------
  always_comb begin
    vout_data = '0;
    vout_be   = '0;
    for (int p = 0; p < NPORT; p++) begin
      g_need[p]   = used_slots(gmap[p]);
      g_enough[p] = olevel[p] >= g_need[p];
      g_any[p]    = g_need[p] != '0;
      for (int s = 0; s < MAPD; s++)
        if (gmap[p][s].vld) begin
          vout_data[gmap[p][s].idx*DW +: DW]  = opeek[p][rank_of(gmap[p], s)];
          vout_be[gmap[p][s].idx*BEW +: BEW]  = '1;
        end
    end
  end

  assign vout_valid = (&g_enough) & (|g_any) & ~cfg_busy;
  assign vout_fire  = vout_valid & vout_ready;

  // ---------------- per-port FIFOs ----------------
  logic [NPORT-1:0] ip_empty, op_empty;
  assign all_empty = (&ip_empty) & (&op_empty);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [0:0][DW-1:0] ihead;
    logic [0:0][DW-1:0] opush_d;

    assign opush_d[0] = op_data[p*DW +: DW];

    vpr_fifo #(.FW(DW), .DEPTH(FDEPTH), .NPUSH(MAPD), .NPEEK(1)) u_ipf (
      .clk(clk), .rst_n(rst_n),
      .push_n(vin_fire ? s_need[p] : '0), .push_d(ipush_d[p]),
      .pop_n(CNTW'(ip_pop[p])), .level(ilevel[p]), .peek(ihead));

    vpr_fifo #(.FW(DW), .DEPTH(FDEPTH), .NPUSH(1), .NPEEK(MAPD)) u_opf (
      .clk(clk), .rst_n(rst_n),
      .push_n(CNTW'(op_push[p])), .push_d(opush_d),
      .pop_n(vout_fire ? g_need[p] : '0), .level(olevel[p]), .peek(opeek[p]));

    assign ip_empty[p]          = ilevel[p] == '0;
    assign op_empty[p]          = olevel[p] == '0;
    assign ip_valid[p]          = ~ip_empty[p];
    assign ip_data[p*DW +: DW]  = ihead[0];
    assign op_ready[p]          = olevel[p] != CNTW'(FDEPTH);

    // R2: an accepted word adds exactly the mapped count to the port FIFO
    a_r2_scatter_count: assert property (@(posedge clk) disable iff (!rst_n)
      vin_fire |=> ilevel[p] == $past(ilevel[p]) + $past(s_need[p]) - CNTW'($past(ip_pop[p])));
    // R5: a gather handshake removes the mapped count from every output FIFO
    a_r5_gather_count: assert property (@(posedge clk) disable iff (!rst_n)
      vout_fire |=> olevel[p] == $past(olevel[p]) - $past(g_need[p]) + CNTW'($past(op_push[p])));
  end

  // R8: a pending load holds off both directions
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_busy |-> !vin_ready && !vout_valid);
  // R7: active tables do not move while any FIFO holds data
  a_r7_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !all_empty |=> $stable(smap) && $stable(gmap));
endmodule

// File: tb/sim_vec_port_router.sv
module sim_vec_port_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_side = 0, cfg_commit = 0;
  logic [1:0] cfg_port = 0, cfg_slot = 0;
  logic [3:0] cfg_ent = 0;
  logic cfg_busy;
  logic vin_valid = 0, vin_ready;
  logic [255:0] vin_data = '0;
  logic [3:0] ip_valid, ip_pop = 0, op_push = 0, op_ready;
  logic [127:0] ip_data, op_data = '0;
  logic vout_valid, vout_ready = 0;
  logic [255:0] vout_data;
  logic [31:0] vout_be;

  int total = 0;
  int bad = 0;
  bit drain_en = 0;

  logic [3:0] sh_s [4][4], act_s [4][4], sh_g [4][4], act_g [4][4];
  logic [31:0] expq [4][$];
  logic [31:0] opq  [4][$];

  always #2 clk = ~clk;

  vec_port_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_side(cfg_side), .cfg_port(cfg_port),
    .cfg_slot(cfg_slot), .cfg_ent(cfg_ent), .cfg_commit(cfg_commit), .cfg_busy(cfg_busy),
    .vin_valid(vin_valid), .vin_ready(vin_ready), .vin_data(vin_data),
    .ip_valid(ip_valid), .ip_data(ip_data), .ip_pop(ip_pop),
    .op_push(op_push), .op_data(op_data), .op_ready(op_ready),
    .vout_valid(vout_valid), .vout_ready(vout_ready), .vout_data(vout_data), .vout_be(vout_be));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_val(input int n, input int e);
    return 32'hA000_0000 | (n << 8) | e;
  endfunction

  // monitor: drains input ports and compares against the scoreboard (R2, R4)
  always @(negedge clk) begin
    for (int p = 0; p < 4; p++) begin
      if (drain_en && rst_n && ip_valid[p]) begin
        if (expq[p].size() == 0)
          chk(0, "R4", $sformatf("unexpected element port%0d", p), ip_data[p*32 +: 32], 0);
        else begin
          logic [31:0] e;
          e = expq[p].pop_front();
          chk(ip_data[p*32 +: 32] == e, "R2", $sformatf("port%0d order", p), ip_data[p*32 +: 32], e);
        end
        ip_pop[p] = 1'b1;
      end else ip_pop[p] = 1'b0;
    end
  end

  task automatic cfg_write(input bit side, input int port, input int slot,
                           input logic [3:0] ent, input bit taken);
    @(negedge clk);
    cfg_we = 1; cfg_side = side; cfg_port = port[1:0]; cfg_slot = slot[1:0]; cfg_ent = ent;
    @(negedge clk);
    cfg_we = 0;
    if (taken) begin
      if (side) sh_g[port][slot] = ent; else sh_s[port][slot] = ent;
    end
  endtask

  task automatic cfg_apply(input bit side);
    @(negedge clk);
    cfg_commit = 1; cfg_side = side;
    @(negedge clk);
    cfg_commit = 0;
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        if (side) act_g[p][s] = sh_g[p][s]; else act_s[p][s] = sh_s[p][s];
  endtask

  // driver: offer one word, push expectations into the scoreboard at acceptance
  task automatic send_vec(input int n);
    @(negedge clk);
    for (int e = 0; e < 8; e++) vin_data[e*32 +: 32] = lane_val(n, e);
    vin_valid = 1;
    #1;
    while (!vin_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        if (act_s[p][s][3]) expq[p].push_back(lane_val(n, act_s[p][s][2:0]));
    @(negedge clk);
    vin_valid = 0;
  endtask

  task automatic drain_all();
    drain_en = 1;
    repeat (12) @(negedge clk);
    #1;
    for (int p = 0; p < 4; p++)
      chk(expq[p].size() == 0, "R2", $sformatf("port%0d missing elements", p), expq[p].size(), 0);
    chk(ip_valid == 4'h0, "R9", "ip_valid after drain", ip_valid, 0);
  endtask

  task automatic op_put(input int p, input logic [31:0] v);
    @(negedge clk);
    op_push[p] = 1; op_data[p*32 +: 32] = v;
    @(negedge clk);
    op_push[p] = 0;
    opq[p].push_back(v);
  endtask

  task automatic take_vout(input string tag);
    logic [255:0] ed;
    logic [31:0] eb;
    ed = '0; eb = '0;
    @(negedge clk);
    #1;
    chk(vout_valid == 1, "R5", {tag, " vout_valid"}, vout_valid, 1);
    for (int p = 0; p < 4; p++) begin
      int r;
      r = 0;
      for (int s = 0; s < 4; s++)
        if (act_g[p][s][3]) begin
          ed[act_g[p][s][2:0]*32 +: 32] = opq[p][r];
          eb[act_g[p][s][2:0]*4 +: 4]   = 4'hF;
          r++;
        end
    end
    chk(vout_data == ed, "R6", {tag, " data"}, vout_data, ed);
    chk(vout_be == eb, "R6", {tag, " byte enables"}, vout_be, eb);
    vout_ready = 1;
    @(negedge clk);
    vout_ready = 0;
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        if (act_g[p][s][3]) void'(opq[p].pop_front());
  endtask

  initial begin
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++) begin
        sh_s[p][s] = 0; act_s[p][s] = 0; sh_g[p][s] = 0; act_g[p][s] = 0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(vin_ready == 1, "R1", "vin_ready", vin_ready, 1);
    chk(vout_valid == 0, "R1", "vout_valid", vout_valid, 0);
    chk(cfg_busy == 0, "R1", "cfg_busy", cfg_busy, 0);
    chk(ip_valid == 0, "R1", "ip_valid", ip_valid, 0);
    chk(op_ready == 4'hF, "R1", "op_ready", op_ready, 4'hF);

    // scatter map: p0 {3,skip,0}, p1 {1,4}, p2 {5,2}, p3 {6,1}; lane 7 unmapped
    cfg_write(0, 0, 0, 4'hB, 1);
    #1;
    chk(cfg_busy == 1, "R8", "busy after write", cfg_busy, 1);
    chk(vin_ready == 0, "R8", "vin_ready while busy", vin_ready, 0);
    cfg_write(0, 0, 2, 4'h8, 1);
    cfg_write(0, 1, 0, 4'h9, 1);
    cfg_write(0, 1, 1, 4'hC, 1);
    cfg_write(0, 2, 0, 4'hD, 1);
    cfg_write(0, 2, 1, 4'hA, 1);
    cfg_write(0, 3, 0, 4'hE, 1);
    cfg_write(0, 3, 1, 4'h9, 1);
    cfg_apply(0);
    #1;
    chk(cfg_busy == 0, "R8", "busy after commit", cfg_busy, 0);
    chk(vin_ready == 1, "R8", "vin_ready after commit", vin_ready, 1);

    // R2 R4: streamed words checked by the scoreboard
    drain_en = 1;
    send_vec(1);
    send_vec(2);
    send_vec(3);
    drain_all();

    // R3: boundary of backpressure with two entries per port, depth 4
    drain_en = 0;
    send_vec(4);
    @(negedge clk); #1;
    chk(vin_ready == 1, "R3", "room for one more word", vin_ready, 1);
    send_vec(5);
    @(negedge clk); #1;
    chk(vin_ready == 0, "R3", "no room", vin_ready, 0);
    chk(ip_valid == 4'hF, "R9", "ip_valid with data", ip_valid, 4'hF);

    // R7: write while FIFOs hold data is ignored
    cfg_write(0, 0, 0, 4'h0, 0);
    #1;
    chk(cfg_busy == 0, "R7", "locked write ignored", cfg_busy, 0);
    drain_all();
    #1;
    chk(vin_ready == 1, "R3", "ready after drain", vin_ready, 1);
    send_vec(6);
    drain_all();

    // gather map: op0 {7,0}, op1 {skip,skip,2}, op3 {skip,5}
    cfg_write(1, 0, 0, 4'hF, 1);
    cfg_write(1, 0, 1, 4'h8, 1);
    cfg_write(1, 1, 2, 4'hA, 1);
    cfg_write(1, 3, 1, 4'hD, 1);
    #1;
    chk(vout_valid == 0, "R8", "vout_valid while busy", vout_valid, 0);
    cfg_apply(1);

    op_put(0, 32'h1111_0001);
    op_put(0, 32'h1111_0002);
    op_put(1, 32'h2222_0001);
    #1;
    chk(vout_valid == 0, "R5", "port3 short", vout_valid, 0);
    op_put(3, 32'h4444_0001);
    take_vout("round1");
    #1;
    chk(vout_valid == 0, "R5", "after round1", vout_valid, 0);

    for (int k = 0; k < 4; k++) op_put(0, 32'h5555_0000 + k);
    #1;
    chk(op_ready[0] == 0, "R9", "op0 full", op_ready, 4'hE);
    op_put(1, 32'h2222_0002);
    op_put(3, 32'h4444_0002);
    take_vout("round2");
    #1;
    chk(vout_valid == 0, "R5", "op1 empty again", vout_valid, 0);
    chk(op_ready == 4'hF, "R9", "op0 has room", op_ready, 4'hF);
    op_put(1, 32'h2222_0003);
    op_put(3, 32'h4444_0003);
    take_vout("round3");
    #1;
    chk(vout_valid == 0, "R5", "all drained", vout_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule